// File: doc/BRIEF.md
# Serial SAR Converter Interface Controller

This block is the digital control side of a 12-bit successive-approximation converter that has a three-wire, read-only serial port. The host drives two lines. The first is an active-low start line: its falling edge opens a conversion frame. The second is a serial clock that steps the frame. The block answers on a single data line, which it can release to high impedance. The 12-bit result comes from a behavioural stand-in for the analog core. It arrives as a parallel offset-binary code and is captured at the start of each frame.

Both host lines are sampled by a faster system clock through synchronisers and edge detectors. Inside a frame, the block counts rising serial-clock edges and shifts out a fixed pattern: three zeros, the 12 result bits MSB first, and one zero at the end. The rising edge at which the host lifts the start line chooses what happens next. It can enter a deeper power-down step, keep the data line driven for back-to-back frames, or end the frame with the line released. The block also reports the track/hold state, the power mode, whether the reference is enabled, and whether the post-reset calibration conversion has finished.

Top module: `sadc_serial_ctrl`

## Requirements
- R1: A falling edge on `start_n` sets `sdo_oe`=1, drives `sdo` to 0 and sets `hold_active`=1.
- R2: In unipolar mode (`bipolar_mode`=0), rising `sclk` edges 1..3 give `sdo`=0, edges 4..15 give `core_code` bits 11 down to 0, and edge 16 gives 0. `sdo` changes only on a `sclk` rising edge or a `start_n` falling edge.
- R3: In bipolar mode (`bipolar_mode`=1), the shifted result is the two's complement form of the offset-binary `core_code`, that is, `core_code` with bit 11 inverted.
- R4: `hold_active` is 0 after reset. It stays 1 through rising edge 13 of a frame and returns to 0 on rising edge 14.
- R5: `cal_done` is 0 after reset. It becomes 1 once a frame reaches its 16th rising edge and then stays 1.
- R6: If `start_n` is still low at the 16th falling `sclk` edge, `sdo_oe` drops on the next `sclk` rising edge or on the next `start_n` rising edge, whichever comes first.
- R7: If `start_n` rises after rising edge 14 or 15 but before edge 16, `sdo_oe` stays 1 through the end of the frame and into the next frame.
- R8: If `start_n` rises after at least 3 and fewer than 14 rising edges while in normal mode, `pwr_mode` becomes 01 (partial power-down) and `sdo_oe` drops. The `pwr_mode` encoding is 00 normal, 01 partial, 10 full.
- R9: The same early rise while in partial mode gives `pwr_mode`=10. Normal mode never goes straight to full. `ref_on` is 0 only in full power-down.
- R10: A frame started while `pwr_mode` is not 00 shifts out only zeros.
- R11: A power-down mode returns to 00 only when `start_n` rises after at least 14 rising edges. An early rise while in full power-down leaves the mode at 10.
- R12: A rise of `start_n` before the 3rd rising edge leaves `pwr_mode` unchanged and drops `sdo_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low conversion start line from the host |
| sclk | input | 1 | Serial clock from the host |
| core_code | input | 12 | Offset-binary result from the analog stand-in |
| bipolar_mode | input | 1 | 1 selects two's complement output coding |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable; 0 models high impedance |
| hold_active | output | 1 | 1 while the track/hold is holding |
| pwr_mode | output | 2 | 00 normal, 01 partial, 10 full power-down |
| ref_on | output | 1 | Reference enabled |
| cal_done | output | 1 | Post-reset calibration conversion has completed |

## Verification
The hardest state to reach is full power-down followed by a wake. Getting there takes two frames in a row, each aborted inside the window between edges 3 and 13. The bench then sends one more early abort to show the mode holds at full. After that it sends a complete frame that first shifts zeros and wakes only on the late release of the start line. The release-to-high-impedance paths are driven one frame at a time: one frame ends on an extra clock edge and another ends on a release of the start line. The continuous path is covered by two frames chained without an idle gap.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int RES_BITS   = 12;
    localparam int LEAD_BITS  = 3;
    localparam int TRAIL_BITS = 1;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_PARTIAL = 2'b01,
        PM_FULL    = 2'b10
    } pmode_t;

    typedef enum logic [1:0] {
        RK_EARLY,
        RK_SLEEP,
        RK_CONT,
        RK_LATE
    } rise_kind_t;

    // Classify where the start line was released inside a frame.
    function automatic rise_kind_t classify_rise(input int edges, input int lead,
                                                 input int cont_edge, input int frame_len);
        if (edges < lead)           return RK_EARLY;
        else if (edges < cont_edge) return RK_SLEEP;
        else if (edges < frame_len) return RK_CONT;
        else                        return RK_LATE;
    endfunction

    // Output coding: offset binary in, two's complement when bipolar.
    function automatic logic [RES_BITS-1:0] code_format(input logic [RES_BITS-1:0] raw,
                                                        input logic bipolar);
        logic [RES_BITS-1:0] r;
        r = raw;
        if (bipolar) r[RES_BITS-1] = ~raw[RES_BITS-1];
        return r;
    endfunction

    function automatic pmode_t deepen(input pmode_t m);
        case (m)
            PM_NORMAL: return PM_PARTIAL;
            default:   return PM_FULL;
        endcase
    endfunction

endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
    parameter int STAGES   = 2,
    parameter bit RST_LVL  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_LVL;
                else if (i == 0) chain[i] <= async_in;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_LVL;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int RES_W   = RES_BITS,
    parameter int LEAD_Z  = LEAD_BITS,
    parameter int TRAIL_Z = TRAIL_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic cs_lvl,
    input  logic sck_rise,
    input  logic sck_fall,
    output logic shift_en,
    output logic sleep_req,
    output logic wake_req,
    output logic oe,
    output logic hold,
    output logic cal_done
);
    localparam int FRAME_LEN = LEAD_Z + RES_W + TRAIL_Z;
    localparam int HOLD_END  = LEAD_Z + RES_W - 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] HOLD_C  = CNT_W'(HOLD_END);

    logic             active;
    logic             tri_pend;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    rise_kind_t       kind;
    logic             rise_in_frame;

    assign cnt_nxt       = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    assign kind          = classify_rise(int'(cnt), LEAD_Z, HOLD_END, FRAME_LEN);
    assign rise_in_frame = !cs_fall && cs_rise && active;
    assign sleep_req     = rise_in_frame && (kind == RK_SLEEP);
    assign wake_req      = rise_in_frame && (kind == RK_CONT || kind == RK_LATE);
    assign shift_en      = sck_rise && active && !tri_pend && !cs_fall && !cs_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            tri_pend <= 1'b0;
            cnt      <= '0;
            oe       <= 1'b0;
            hold     <= 1'b0;
            cal_done <= 1'b0;
        end else if (cs_fall) begin
            active   <= 1'b1;
            tri_pend <= 1'b0;
            cnt      <= '0;
            oe       <= 1'b1;
            hold     <= 1'b1;
        end else if (rise_in_frame) begin
            tri_pend <= 1'b0;
            if (kind != RK_CONT) begin
                active <= 1'b0;
                oe     <= 1'b0;
                hold   <= 1'b0;
            end
        end else if (sck_rise && active) begin
            if (tri_pend) begin
                active   <= 1'b0;
                oe       <= 1'b0;
                tri_pend <= 1'b0;
            end else begin
                cnt <= cnt_nxt;
                if (cnt_nxt == HOLD_C) hold <= 1'b0;
                if (cnt_nxt == FRAME_C) begin
                    cal_done <= 1'b1;
                    if (cs_lvl) active <= 1'b0;
                end
            end
        end else if (sck_fall && active && (cnt >= FRAME_C) && !cs_lvl) begin
            tri_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/sadc_pwr_fsm.sv
module sadc_pwr_fsm
    import sadc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_req,
    input  logic   wake_req,
    output pmode_t mode
);
    always_ff @(posedge clk) begin
        if (rst)            mode <= PM_NORMAL;
        else if (wake_req)  mode <= PM_NORMAL;
        else if (sleep_req) mode <= deepen(mode);
    end
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
    import sadc_pkg::*;
#(
    parameter int RES_W   = RES_BITS,
    parameter int LEAD_Z  = LEAD_BITS,
    parameter int TRAIL_Z = TRAIL_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             blank,
    input  logic             bipolar,
    input  logic [RES_W-1:0] raw_code,
    input  logic             shift_en,
    output logic             sdo
);
    localparam int FRAME_LEN = LEAD_Z + RES_W + TRAIL_Z;

    logic [FRAME_LEN-1:0] sreg;
    logic [RES_W-1:0]     coded;

    assign coded = blank ? '0 : code_format(raw_code, bipolar);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            sdo  <= 1'b0;
        end else if (load) begin
            sreg <= {{LEAD_Z{1'b0}}, coded, {TRAIL_Z{1'b0}}};
            sdo  <= 1'b0;
        end else if (shift_en) begin
            sdo  <= sreg[FRAME_LEN-1];
            sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sadc_serial_ctrl.sv
module sadc_serial_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_W       = RES_BITS,
    parameter int LEAD_Z      = LEAD_BITS,
    parameter int TRAIL_Z     = TRAIL_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] core_code,
    input  logic             bipolar_mode,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             hold_active,
    output logic [1:0]       pwr_mode,
    output logic             ref_on,
    output logic             cal_done
);
    logic   cs_lvl, cs_rise, cs_fall;
    logic   sck_lvl, sck_rise, sck_fall;
    logic   shift_en, sleep_req, wake_req;
    pmode_t mode;

    sadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .async_in(start_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

    sadc_edge_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .async_in(sclk),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall));

    sadc_frame_seq #(.RES_W(RES_W), .LEAD_Z(LEAD_Z), .TRAIL_Z(TRAIL_Z)) u_seq (
        .clk(clk), .rst(rst),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_lvl(cs_lvl),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .shift_en(shift_en), .sleep_req(sleep_req), .wake_req(wake_req),
        .oe(sdo_oe), .hold(hold_active), .cal_done(cal_done));

    sadc_pwr_fsm u_pwr (
        .clk(clk), .rst(rst),
        .sleep_req(sleep_req), .wake_req(wake_req), .mode(mode));

    sadc_shifter #(.RES_W(RES_W), .LEAD_Z(LEAD_Z), .TRAIL_Z(TRAIL_Z)) u_shift (
        .clk(clk), .rst(rst),
        .load(cs_fall), .blank(mode != PM_NORMAL), .bipolar(bipolar_mode),
        .raw_code(core_code), .shift_en(shift_en), .sdo(sdo));

    assign pwr_mode = mode;
    assign ref_on   = (mode != PM_FULL);

    logic unused_sck_lvl;
    assign unused_sck_lvl = sck_lvl;
endmodule

// File: rtl/sadc_serial_ctrl_chk.sv
module sadc_serial_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       hold_active,
    input logic [1:0] pwr_mode,
    input logic       cal_done,
    input logic       sck_rise_e,
    input logic       cs_rise_e,
    input logic       cs_fall_e
);
    // R1
    frame_open_chk: assert property (@(posedge clk) disable iff (rst)
        cs_fall_e |=> (sdo_oe && !sdo && hold_active));

    // R2
    sdo_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!sck_rise_e && !cs_fall_e) |=> $stable(sdo));

    // R5
    cal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> cal_done);

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sdo_oe) |-> $past(sck_rise_e || cs_rise_e));

    // R8
    mode_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pwr_mode) |-> $past(cs_rise_e));

    // R9
    no_skip_full_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'b00) |=> (pwr_mode != 2'b10));
endmodule

bind sadc_serial_ctrl sadc_serial_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold_active(hold_active), .pwr_mode(pwr_mode), .cal_done(cal_done),
    .sck_rise_e(sck_rise), .cs_rise_e(cs_rise), .cs_fall_e(cs_fall));

// File: tb/test_sadc_serial_ctrl.sv
module test_sadc_serial_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b1;
    logic        sclk = 1'b0;
    logic [11:0] core_code = '0;
    logic        bipolar_mode = 1'b0;
    logic        sdo, sdo_oe, hold_active, ref_on, cal_done;
    logic [1:0]  pwr_mode;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];
    event  bit_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    sadc_serial_ctrl i_sadc_serial_ctrl (
        .clk(clk), .rst(rst), .start_n(start_n), .sclk(sclk),
        .core_code(core_code), .bipolar_mode(bipolar_mode),
        .sdo(sdo), .sdo_oe(sdo_oe), .hold_active(hold_active),
        .pwr_mode(pwr_mode), .ref_on(ref_on), .cal_done(cal_done));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops each expected serial bit and compares it with sdo.
    initial begin
        forever begin
            @(bit_ev);
            if (exp_q.size() != 0) begin
                check(tag_q.pop_front(), int'(sdo), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic wait_settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk); start_n = v; wait_settle();
    endtask

    task automatic sck_edge(input logic v);
        @(negedge clk); sclk = v; wait_settle();
    endtask

    // Driver: one frame; release_at = edge after which start_n rises (0 = stays low).
    task automatic run_frame(input logic [11:0] code, input bit bip, input bit blank,
                             input int release_at, input string tag);
        logic [11:0] coded;
        int last;
        coded = blank ? 12'h000 : (bip ? (code ^ 12'h800) : code);
        core_code = code;
        bipolar_mode = bip;
        set_cs(1'b0);
        last = (release_at >= 3 && release_at < 14) ? release_at :
               (release_at > 0 && release_at < 3) ? release_at : 16;
        for (int e = 1; e <= last; e++) begin
            exp_q.push_back((e >= 4 && e <= 15) ? coded[15-e] : 1'b0);
            tag_q.push_back(tag);
            sck_edge(1'b1);
            ->bit_ev;
            if (!blank && e == 13) check("R4 hold at edge 13", int'(hold_active), 1);
            if (!blank && e == 14) check("R4 track at edge 14", int'(hold_active), 0);
            sck_edge(1'b0);
            if (e == release_at) set_cs(1'b1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_settle();
        check("R4 reset oe", int'(sdo_oe), 0);
        check("R4 reset hold", int'(hold_active), 0);
        check("R9 reset mode", int'(pwr_mode), 0);
        check("R9 reset ref", int'(ref_on), 1);
        check("R5 reset cal", int'(cal_done), 0);

        // R1 start of frame
        core_code = 12'hA5C;
        set_cs(1'b0);
        check("R1 oe on fall", int'(sdo_oe), 1);
        check("R1 sdo low on fall", int'(sdo), 0);
        check("R1 hold on fall", int'(hold_active), 1);
        set_cs(1'b1);

        // R2 unipolar frame, line kept low; R6 release via extra clock edge
        run_frame(12'hA5C, 1'b0, 1'b0, 0, "R2 unipolar bit");
        check("R5 cal after frame", int'(cal_done), 1);
        check("R6 oe kept after 16th fall", int'(sdo_oe), 1);
        sck_edge(1'b1);
        check("R6 oe off on next sclk", int'(sdo_oe), 0);
        sck_edge(1'b0);
        set_cs(1'b1);

        // R3 bipolar frame; R6 release via start line rise
        run_frame(12'h123, 1'b1, 1'b0, 0, "R3 bipolar bit");
        check("R6 oe kept before rise", int'(sdo_oe), 1);
        set_cs(1'b1);
        check("R6 oe off on start rise", int'(sdo_oe), 0);

        // R7 continuous frames
        run_frame(12'h7FF, 1'b0, 1'b0, 14, "R7 cont bit A");
        check("R7 oe kept after frame", int'(sdo_oe), 1);
        run_frame(12'h001, 1'b0, 1'b0, 15, "R7 cont bit B");
        check("R7 oe kept after second", int'(sdo_oe), 1);
        check("R7 mode normal", int'(pwr_mode), 0);

        // R12 early rise
        run_frame(12'h3C3, 1'b0, 1'b0, 2, "R12 early bit");
        check("R12 mode unchanged", int'(pwr_mode), 0);
        check("R12 oe off", int'(sdo_oe), 0);

        // R8 partial power-down
        run_frame(12'h456, 1'b0, 1'b0, 8, "R8 bit");
        check("R8 mode partial", int'(pwr_mode), 1);
        check("R8 oe off", int'(sdo_oe), 0);
        check("R9 ref on in partial", int'(ref_on), 1);

        // R9 full power-down from partial, R10 zeros
        run_frame(12'hFFF, 1'b0, 1'b1, 8, "R10 partial zero bit");
        check("R9 mode full", int'(pwr_mode), 2);
        check("R9 ref off in full", int'(ref_on), 0);

        // R11 early rise while full stays full
        run_frame(12'hFFF, 1'b0, 1'b1, 10, "R10 full zero bit");
        check("R11 stays full", int'(pwr_mode), 2);

        // R11 wake after a full frame
        run_frame(12'hFFF, 1'b1, 1'b1, 0, "R10 wake frame zero bit");
        set_cs(1'b1);
        check("R11 mode normal after wake", int'(pwr_mode), 0);
        check("R11 ref back on", int'(ref_on), 1);
        check("R5 cal still set", int'(cal_done), 1);

        // R2 normal data after wake
        run_frame(12'h5A3, 1'b0, 1'b0, 0, "R2 post-wake bit");
        set_cs(1'b1);
        check("R2 queue drained", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule